// File: doc/BRIEF.md
# Integer Instruction Decode Stage

This block is the decode stage of a small 32-bit integer pipeline. Each clock it takes one instruction word and the program counter that fetched it. It reads the two source operands from an internal 32-entry register file and builds the sign-extended immediate for the instruction's format. It also reduces the operation to a few control bits for the execute stage: a subtract/arithmetic-shift bit, a signed-compare bit, a jump bit, a branch bit and a 5-bit shift amount. Every output is registered, so the results for an instruction appear one clock after it is presented.

The writeback stage updates the register file through a separate address/data/enable port. Register 0 is hard-wired to zero. A write that lands in the same cycle as a read of the same register is forwarded to the read. A synchronous flush clears all registered outputs and turns the slot into a bubble, but it does not block a writeback. A synchronous active-low reset clears the outputs and the register file.

The supported operations are LUI, JAL, JALR, BEQ, LW, SW, the register-immediate ALU group (ADDI, SLTI, SLTIU, XORI, ORI, ANDI, SLLI, SRLI, SRAI) and the register-register group (ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR, AND). The opcodes follow the standard RV32I encoding: LUI 0110111, JAL 1101111, JALR 1100111, branch 1100011, load 0000011, store 0100011, register-immediate 0010011, register-register 0110011.

Top module: `rvdec_stage`

## Requirements
- R1: Register 0 reads as zero on both source outputs, also in the cycle where a write to address 0 is attempted and after it.
- R2: A write through wb_en/wb_addr/wb_data to registers 1..31 is returned on the next decode. src1_q carries the register named by instr[19:15] and src2_q the register named by instr[24:20], for every instruction.
- R3: If wb_en writes register k (k not 0) in the same cycle that the instruction names k as a source, the registered source output carries the new wb_data.
- R4: For LUI (opcode 0110111), imm_q holds instr[31:12] in bits 31..12, and bits 11..0 are zero.
- R5: I-type formats (JALR, load, register-immediate) give imm_q = instr[31:20] sign-extended from bit 31. The store format gives imm_q = {instr[31:25], instr[11:7]} sign-extended. Register-register instructions give imm_q = 0.
- R6: The branch format gives imm_q = {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended. The JAL format gives imm_q = {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended. Bit 0 is zero in both.
- R7: arith_q equals instr[30] for SUB/ADD (funct3 000 on opcode 0110011), for SRL/SRA (funct3 101 on 0110011) and for SRLI/SRAI (funct3 101 on 0010011). It is 0 for every other instruction, including ADDI with instr[30] set.
- R8: signed_q is 0 for SLTU and SLTIU (funct3 011 on 0110011 and 0010011) and 1 for every other decoded instruction.
- R9: jump_q is 1 for JAL and JALR. branch_q is 1 for BEQ (funct3 000 on 1100011). Both are 0 otherwise.
- R10: shamt_q is instr[24:20] for SLLI/SRLI/SRAI (funct3 001/101 on 0010011), src2 bits 4..0 for SLL/SRL/SRA (funct3 001/101 on 0110011), and 0 otherwise.
- R11: pc_q equals the pc_in applied with the instruction, one clock later.
- R12: With flush high at a clock edge, every output is zero after that edge. A writeback in the same cycle still updates the register file.
- R13: With rst_n low at a clock edge, every output is zero after that edge and all registers read as zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Synchronous bubble insert |
| instr | input | 32 | Instruction word to decode |
| pc_in | input | 32 | Address of the instruction |
| wb_en | input | 1 | Register file write enable |
| wb_addr | input | 5 | Register file write address |
| wb_data | input | 32 | Register file write data |
| src1_q | output | 32 | First source operand |
| src2_q | output | 32 | Second source operand |
| shamt_q | output | 5 | Shift amount |
| arith_q | output | 1 | Subtract / arithmetic shift select |
| signed_q | output | 1 | Signed compare select |
| jump_q | output | 1 | Unconditional jump |
| branch_q | output | 1 | Conditional branch |
| pc_q | output | 32 | Registered program counter |
| imm_q | output | 32 | Registered immediate |

## Verification
On every cycle the assertions check these behaviours: the register-0 read, the same-cycle forwarding of a write, read-after-write on the next decode, the one-clock PC delay, the flush clear, the LUI immediate, the even B/J offsets and the exclusive jump/branch flags. Other behaviours can only be shown by the bench's scenarios, using a reference model of the register contents: the exact contents of all 31 registers, the sign extension and bit scrambling of each immediate format, the full decode of arith, signed and shamt for each operation, the writeback that survives a flush, and the register file being wiped by reset.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int XLEN     = 32;
    localparam int ILEN     = 32;
    localparam int NREGS    = 32;
    localparam int RAW      = $clog2(NREGS);
    localparam int SHW      = $clog2(XLEN);

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;

    localparam logic [2:0] F3_ADDSUB  = 3'b000;
    localparam logic [2:0] F3_SLL     = 3'b001;
    localparam logic [2:0] F3_SLTU    = 3'b011;
    localparam logic [2:0] F3_SR      = 3'b101;

    typedef enum logic [2:0] {
        FMT_NONE,
        FMT_I,
        FMT_S,
        FMT_B,
        FMT_U,
        FMT_J
    } imm_fmt_e;

    typedef struct packed {
        logic     arith;
        logic     sgn;
        logic     jump;
        logic     branch;
        logic     sh_from_imm;
        logic     sh_from_reg;
        imm_fmt_e fmt;
    } dec_ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] src1;
        logic [XLEN-1:0] src2;
        logic [SHW-1:0]  shamt;
        logic            arith;
        logic            sgn;
        logic            jump;
        logic            branch;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] imm;
    } dec_out_t;

    function automatic logic is_shift(input logic [2:0] f3);
        return (f3 == F3_SLL) || (f3 == F3_SR);
    endfunction

endpackage

// File: rtl/rvdec_regfile.sv
module rvdec_regfile #(
    parameter int XLEN  = rvdec_pkg::XLEN,
    parameter int DEPTH = rvdec_pkg::NREGS,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [XLEN-1:0]          wr_data,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][XLEN-1:0] rd_data
);

    logic [XLEN-1:0] mem [1:DEPTH-1];
    logic            wr_live;

    assign wr_live = wr_en && (wr_addr != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_live) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == '0) begin
                rd_data[p] = '0;
            end else if (wr_live && (wr_addr == rd_addr[p])) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = mem[rd_addr[p]];
            end
        end
    end

endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       alt,
    output dec_ctrl_t  ctrl
);

    always_comb begin
        ctrl     = '0;
        ctrl.sgn = 1'b1;
        ctrl.fmt = FMT_NONE;
        case (opcode)
            OPC_LUI:   ctrl.fmt = FMT_U;
            OPC_JAL: begin
                ctrl.fmt  = FMT_J;
                ctrl.jump = 1'b1;
            end
            OPC_JALR: begin
                ctrl.fmt  = FMT_I;
                ctrl.jump = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl.fmt    = FMT_B;
                ctrl.branch = (funct3 == F3_ADDSUB);
            end
            OPC_LOAD:  ctrl.fmt = FMT_I;
            OPC_STORE: ctrl.fmt = FMT_S;
            OPC_OPIMM: begin
                ctrl.fmt         = FMT_I;
                ctrl.sh_from_imm = is_shift(funct3);
                ctrl.arith       = (funct3 == F3_SR) && alt;
                ctrl.sgn         = (funct3 != F3_SLTU);
            end
            OPC_OP: begin
                ctrl.fmt         = FMT_NONE;
                ctrl.sh_from_reg = is_shift(funct3);
                ctrl.arith       = ((funct3 == F3_SR) || (funct3 == F3_ADDSUB)) && alt;
                ctrl.sgn         = (funct3 != F3_SLTU);
            end
            default: ctrl.fmt = FMT_NONE;
        endcase
    end

endmodule

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
    import rvdec_pkg::*;
#(
    parameter int XLEN = rvdec_pkg::XLEN
) (
    input  logic [31:7]     ins,
    input  imm_fmt_e        fmt,
    output logic [XLEN-1:0] imm
);

    logic s;

    assign s = ins[31];

    always_comb begin
        case (fmt)
            FMT_I:   imm = {{(XLEN-11){s}}, ins[30:20]};
            FMT_S:   imm = {{(XLEN-11){s}}, ins[30:25], ins[11:7]};
            FMT_B:   imm = {{(XLEN-12){s}}, ins[7], ins[30:25], ins[11:8], 1'b0};
            FMT_U:   imm = {{(XLEN-31){s}}, ins[30:12], 12'b0};
            FMT_J:   imm = {{(XLEN-20){s}}, ins[19:12], ins[20], ins[30:21], 1'b0};
            default: imm = '0;
        endcase
    end

endmodule

// File: rtl/rvdec_stage.sv
module rvdec_stage
    import rvdec_pkg::*;
#(
    parameter int XW  = rvdec_pkg::XLEN,
    parameter int NR  = rvdec_pkg::NREGS,
    localparam int AW = $clog2(NR),
    localparam int SW = $clog2(XW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [31:0]   instr,
    input  logic [XW-1:0] pc_in,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [XW-1:0] wb_data,
    output logic [XW-1:0] src1_q,
    output logic [XW-1:0] src2_q,
    output logic [SW-1:0] shamt_q,
    output logic          arith_q,
    output logic          signed_q,
    output logic          jump_q,
    output logic          branch_q,
    output logic [XW-1:0] pc_q,
    output logic [XW-1:0] imm_q
);

    logic [1:0][AW-1:0] rd_addr;
    logic [1:0][XW-1:0] rd_data;
    dec_ctrl_t          ctrl;
    logic [XW-1:0]      imm_d;
    logic [SW-1:0]      shamt_d;
    dec_out_t           nxt;
    dec_out_t           cur;

    assign rd_addr[0] = instr[15 +: AW];
    assign rd_addr[1] = instr[20 +: AW];

    rvdec_regfile #(
        .XLEN  (XW),
        .DEPTH (NR),
        .NRD   (2)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_en),
        .wr_addr (wb_addr),
        .wr_data (wb_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rvdec_ctrl u_ctrl (
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .alt    (instr[30]),
        .ctrl   (ctrl)
    );

    rvdec_immgen #(
        .XLEN (XW)
    ) u_imm (
        .ins (instr[31:7]),
        .fmt (ctrl.fmt),
        .imm (imm_d)
    );

    always_comb begin
        if (ctrl.sh_from_imm) begin
            shamt_d = instr[20 +: SW];
        end else if (ctrl.sh_from_reg) begin
            shamt_d = rd_data[1][SW-1:0];
        end else begin
            shamt_d = '0;
        end
    end

    always_comb begin
        nxt.src1   = rd_data[0];
        nxt.src2   = rd_data[1];
        nxt.shamt  = shamt_d;
        nxt.arith  = ctrl.arith;
        nxt.sgn    = ctrl.sgn;
        nxt.jump   = ctrl.jump;
        nxt.branch = ctrl.branch;
        nxt.pc     = pc_in;
        nxt.imm    = imm_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign src1_q   = cur.src1;
    assign src2_q   = cur.src2;
    assign shamt_q  = cur.shamt;
    assign arith_q  = cur.arith;
    assign signed_q = cur.sgn;
    assign jump_q   = cur.jump;
    assign branch_q = cur.branch;
    assign pc_q     = cur.pc;
    assign imm_q    = cur.imm;

endmodule

// File: rtl/rvdec_stage_chk.sv
module rvdec_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic [31:0] instr,
    input logic [31:0] pc_in,
    input logic        wb_en,
    input logic [4:0]  wb_addr,
    input logic [31:0] wb_data,
    input logic [31:0] src1_q,
    input logic [31:0] src2_q,
    input logic [4:0]  shamt_q,
    input logic        arith_q,
    input logic        signed_q,
    input logic        jump_q,
    input logic        branch_q,
    input logic [31:0] pc_q,
    input logic [31:0] imm_q
);

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && instr[19:15] == 5'd0) |=> (src1_q == 32'd0)); // R1

    AST_SAME_CYCLE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wb_en && wb_addr != 5'd0 && wb_addr == instr[24:20]) |=> (src2_q == $past(wb_data))); // R3

    AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_addr != 5'd0) ##1 (!flush && !wb_en && instr[19:15] == $past(wb_addr))
        |=> (src1_q == $past(wb_data, 2))); // R2

    AST_UPPER_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && instr[6:0] == 7'b0110111) |=> (imm_q == {$past(instr[31:12]), 12'd0})); // R4

    AST_BJ_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (instr[6:0] == 7'b1100011 || instr[6:0] == 7'b1101111)) |=> (imm_q[0] == 1'b0)); // R6

    AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jump_q, branch_q})); // R9

    AST_PC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (pc_q == $past(pc_in))); // R11

    AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ({src1_q, src2_q, shamt_q, arith_q, signed_q, jump_q, branch_q, pc_q, imm_q} == '0)); // R12

endmodule

bind rvdec_stage rvdec_stage_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .instr    (instr),
    .pc_in    (pc_in),
    .wb_en    (wb_en),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .src1_q   (src1_q),
    .src2_q   (src2_q),
    .shamt_q  (shamt_q),
    .arith_q  (arith_q),
    .signed_q (signed_q),
    .jump_q   (jump_q),
    .branch_q (branch_q),
    .pc_q     (pc_q),
    .imm_q    (imm_q)
);

// File: tb/rvdec_stage_tb.sv
module rvdec_stage_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] instr = NOP;
    logic [31:0] pc_in = '0;
    logic        wb_en = 1'b0;
    logic [4:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic [31:0] src1_q, src2_q, pc_q, imm_q;
    logic [4:0]  shamt_q;
    logic        arith_q, signed_q, jump_q, branch_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvdec_stage u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .instr(instr), .pc_in(pc_in),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .src1_q(src1_q), .src2_q(src2_q), .shamt_q(shamt_q), .arith_q(arith_q),
        .signed_q(signed_q), .jump_q(jump_q), .branch_q(branch_q), .pc_q(pc_q), .imm_q(imm_q)
    );

    typedef struct {
        string        rq;
        logic [136:0] v;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] model [32];
    logic [31:0] pc_cur = 32'h0000_1000;

    function automatic logic [31:0] rdm(input logic [4:0] a);
        return (a == 5'd0) ? 32'd0 : model[a];
    endfunction

    function automatic logic [31:0] r_enc(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] i_enc(input logic [11:0] im, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
        return {im, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] s_enc(input logic [11:0] im, input logic [4:0] rs2, input logic [4:0] rs1);
        return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] b_enc(input logic [12:0] im, input logic [4:0] rs2, input logic [4:0] rs1);
        return {im[12], im[10:5], rs2, rs1, 3'b000, im[4:1], im[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] j_enc(input logic [20:0] im, input logic [4:0] rd);
        return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
    endfunction

    // Drive one decode slot; when chk is set, push the expected outputs.
    task automatic issue(input string rq, input logic [31:0] ins, input logic fl,
                         input logic we, input logic [4:0] wa, input logic [31:0] wd,
                         input bit chk, input logic [31:0] im, input logic ar, input logic sg,
                         input logic jp, input logic br, input int shsel);
        exp_t        it;
        logic [31:0] s1, s2;
        logic [4:0]  sh;
        @(negedge clk);
        instr   = ins;
        pc_in   = pc_cur;
        flush   = fl;
        wb_en   = we;
        wb_addr = wa;
        wb_data = wd;
        if (we && wa != 5'd0) model[wa] = wd;
        if (chk) begin
            s1 = rdm(ins[19:15]);
            s2 = rdm(ins[24:20]);
            sh = (shsel == 1) ? ins[24:20] : (shsel == 2) ? s2[4:0] : 5'd0;
            it.rq = rq;
            it.v  = fl ? '0 : {s1, s2, sh, ar, sg, jp, br, pc_cur, im};
            sb.push_back(it);
        end
        pc_cur = pc_cur + 32'd4;
    endtask

    task automatic dec(input string rq, input logic [31:0] ins, input logic [31:0] im,
                       input logic ar, input logic sg, input logic jp, input logic br, input int shsel);
        issue(rq, ins, 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, im, ar, sg, jp, br, shsel);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        issue("", NOP, 1'b0, 1'b1, a, d, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    // Monitor: pop one expected item per edge after it was driven.
    initial begin
        exp_t         it;
        logic [136:0] got;
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                #(CLK_PERIOD/4);
                got = {src1_q, src2_q, shamt_q, arith_q, signed_q, jump_q, branch_q, pc_q, imm_q};
                n_chk++;
                if (got !== it.v) begin
                    n_fail++;
                    $display("FAIL %s got %h exp %h", it.rq, got, it.v);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        // R13: outputs cleared while reset is held
        rst_n = 1'b0;
        issue("R13 reset", r_enc(7'h00, 5'd3, 5'd2, 3'b000, 5'd1), 1'b0, 1'b0, 5'd0, 32'd0,
              1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        it_zero_fix();
        @(negedge clk);
        rst_n = 1'b1;

        // fill registers, including an attempted write to register 0
        wr(5'd0, 32'hDEAD_BEEF);
        for (int i = 1; i < 32; i++) wr(5'(i), 32'h1357_9BDF + 32'(i) * 32'h0110_0011);

        // R1 zero register
        dec("R1 rs1=x0", i_enc(12'h000, 5'd0, 3'b000, 5'd5, 7'b0010011), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        // R2 all registers through rs1 and rs2 (imm low bits name rs2)
        for (int i = 1; i < 32; i++)
            dec("R2 readback", i_enc(12'(i), 5'(i), 3'b000, 5'd1, 7'b0010011), 32'(i), 1'b0, 1'b1, 1'b0, 1'b0, 0);
        dec("R2 ADD", r_enc(7'h00, 5'd9, 5'd7, 3'b000, 5'd1), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        // R3 same-cycle forward on both ports
        issue("R3 bypass", r_enc(7'h00, 5'd12, 5'd12, 3'b100, 5'd2), 1'b0, 1'b1, 5'd12, 32'hA5A5_0F0F,
              1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        issue("R1 write x0 bypass", r_enc(7'h00, 5'd0, 5'd0, 3'b110, 5'd2), 1'b0, 1'b1, 5'd0, 32'hFFFF_FFFF,
              1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        // R4 upper immediate
        dec("R4 LUI", {20'hF0F0F, 5'd3, 7'b0110111}, 32'hF0F0_F000, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        // R5 I and S immediates
        dec("R5 ADDI neg", i_enc(12'hFFB, 5'd4, 3'b000, 5'd6, 7'b0010011), 32'hFFFF_FFFB, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        dec("R5 LW pos", i_enc(12'h7FF, 5'd8, 3'b010, 5'd6, 7'b0000011), 32'h0000_07FF, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        dec("R5 SW neg", s_enc(12'hFF0, 5'd11, 5'd10), 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        dec("R5 XORI", i_enc(12'h123, 5'd13, 3'b100, 5'd6, 7'b0010011), 32'h0000_0123, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        // R6 and R9 branch/jump immediates and flags
        dec("R6 BEQ neg", b_enc(13'h1FF8, 5'd15, 5'd14), 32'hFFFF_FFF8, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        dec("R6 BEQ pos", b_enc(13'h0802, 5'd2, 5'd1), 32'h0000_0802, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        dec("R6 JAL pos", j_enc(21'h0_0800, 5'd1), 32'h0000_0800, 1'b0, 1'b1, 1'b1, 1'b0, 0);
        dec("R6 JAL neg", j_enc(21'h1F_FFFC, 5'd1), 32'hFFFF_FFFC, 1'b0, 1'b1, 1'b1, 1'b0, 0);
        dec("R9 JALR", i_enc(12'hFFF, 5'd16, 3'b000, 5'd1, 7'b1100111), 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 0);

        // R7 arith bit
        dec("R7 SUB", r_enc(7'h20, 5'd18, 5'd17, 3'b000, 5'd2), 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 0);
        dec("R7 SRA", r_enc(7'h20, 5'd19, 5'd17, 3'b101, 5'd2), 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2);
        dec("R7 SRAI", i_enc(12'h407, 5'd20, 3'b101, 5'd2, 7'b0010011), 32'h0000_0407, 1'b1, 1'b1, 1'b0, 1'b0, 1);
        dec("R7 ADDI bit30", i_enc(12'h400, 5'd20, 3'b000, 5'd2, 7'b0010011), 32'h0000_0400, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        // R8 signed bit
        dec("R8 SLTU", r_enc(7'h00, 5'd22, 5'd21, 3'b011, 5'd2), 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        dec("R8 SLTIU", i_enc(12'hF80, 5'd21, 3'b011, 5'd2, 7'b0010011), 32'hFFFF_FF80, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        dec("R8 SLT", r_enc(7'h00, 5'd22, 5'd21, 3'b010, 5'd2), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        // R10 shift amounts
        dec("R10 SLL", r_enc(7'h00, 5'd23, 5'd24, 3'b001, 5'd2), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2);
        dec("R10 SRL", r_enc(7'h00, 5'd25, 5'd24, 3'b101, 5'd2), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2);
        dec("R10 SLLI", i_enc(12'h01F, 5'd24, 3'b001, 5'd2, 7'b0010011), 32'h0000_001F, 1'b0, 1'b1, 1'b0, 1'b0, 1);
        dec("R10 SRLI", i_enc(12'h00D, 5'd24, 3'b101, 5'd2, 7'b0010011), 32'h0000_000D, 1'b0, 1'b1, 1'b0, 1'b0, 1);

        // R12 flush bubble with a writeback that must survive
        issue("R12 flush", r_enc(7'h20, 5'd20, 5'd20, 3'b101, 5'd2), 1'b1, 1'b1, 5'd20, 32'h0BAD_F00D,
              1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        dec("R12 write kept", r_enc(7'h00, 5'd20, 5'd20, 3'b111, 5'd2), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        // R13 reset mid-run wipes registers
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        @(negedge clk);
        rst_n = 1'b1;
        dec("R13 regs cleared", r_enc(7'h00, 5'd9, 5'd7, 3'b000, 5'd1), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        dec("R11 pc", i_enc(12'h000, 5'd31, 3'b110, 5'd1, 7'b0010011), 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0);

        @(negedge clk);
        wb_en = 1'b0;
        flush = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // The reset slot expects all zeros: replace its expected value.
    task automatic it_zero_fix();
        exp_t it;
        it = sb.pop_back();
        it.v = '0;
        sb.push_back(it);
    endtask

endmodule